// File: doc/BRIEF.md
# Output Port Bank with Per-Group Tristate Control

This block drives 26 output-only pins, split into four groups of 8, 8, 6 and 4 bits. Each pin has a data register bit and an output-enable. Fourteen tristate control bits decide whether a pin is driven or floats. Groups 0 and 1 have one control bit per nibble. Groups 2 and 3 have one control bit per pin. A CPU reaches every register through a byte-wide register bus with a 3-bit offset: a write strobe stores the value, and a combinational read returns what is stored.

A mode input selects how the pins are driven. In single-chip mode the registers drive the pins. In expansion mode an external bus controller drives all 26 pins instead: 20 address lines, the read and write strobes, three chip enables and a bus acknowledge. All pins are enabled in that mode. The registers stay readable and writable in expansion mode, but they do not reach the pins. Both pin vectors are registered, so they change one cycle after the cause.

Top module: `outport_bank`

## Requirements
- R1: After reset every data and tristate register reads 0, `pin_oe` is all ones and `pin_out` is all zeros.
- R2: Register map by `reg_addr`:
  - Offsets 0, 1, 2 and 3 hold the data of groups 0, 1, 2 and 3, with the group's bit k in register bit k.
  - Offset 4 holds the nibble controls in bits 0 to 3: group 0 low, group 0 high, group 1 low, group 1 high.
  - Offset 5 bits 0 to 5 hold the per-pin controls of group 2.
  - Offset 6 bits 0 to 3 hold the per-pin controls of group 3.
  - Offset 7 and all unused upper bits read 0. Writes to them are dropped.
- R3: In single-chip mode a tristate control bit of 1 drives `pin_oe` low for every pin it covers, and `pin_out` reads 0 on those pins. A control bit of 0 drives `pin_oe` high. The nibble controls of groups 0 and 1 cover pins 4n to 4n+3, counting from the group's bit 0.
- R4: In single-chip mode a driven pin shows its data bit. Pin order: pins 0–7 are group 0, pins 8–15 are group 1, pins 16–21 are group 2 and pins 22–25 are group 3.
- R5: Data written while a pin is tristated is stored. It appears on the pin once the pin's control bit is cleared, with no further data write.
- R6: A register write takes effect at the clock edge that samples `reg_wr`. The pins show the new value one clock edge later.
- R7: In expansion mode `pin_oe` is all ones, whatever the tristate registers hold. The pins are fed as follows, one edge after the bus inputs are sampled:
  - pins 0–19 carry `bus_addr`,
  - pin 20 carries `bus_rd` and pin 21 carries `bus_wr`,
  - pins 22–24 carry `bus_ce[0..2]`,
  - pin 25 carries `bus_ack`.
- R8: In expansion mode register writes and reads work as in R2 and leave the pins unchanged. Reads return register contents, not pin state. When the block returns to single-chip mode, the pins show the stored registers one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_exp | input | 1 | 1 = expansion (bus drives pins), 0 = single-chip |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| bus_addr | input | 20 | External bus address |
| bus_rd | input | 1 | External read strobe |
| bus_wr | input | 1 | External write strobe |
| bus_ce | input | 3 | External chip enables |
| bus_ack | input | 1 | External bus acknowledge |
| pin_out | output | 26 | Registered pin output values |
| pin_oe | output | 26 | Registered pin output enables (1 = driven) |

## Verification
The bench builds the block with the package's group widths of 8, 8, 6 and 4. These widths give the full 26-pin map, all 14 tristate controls, the masked upper register bits and the unused offset 7. Directed tasks cover each tristate control separately, including both nibble halves. They also cover a value written while its pin is tristated and revealed later, the one-cycle gap between a register write and the pin change, and a switch into and back out of expansion mode while the registers are being written.

// File: rtl/outport_pkg.sv
// Shared geometry of the output port bank: group widths, tristate layout,
// register offsets and the pin-to-control mapping.
package outport_pkg;
    localparam int G0_W    = 8;
    localparam int G1_W    = 8;
    localparam int G2_W    = 6;
    localparam int G3_W    = 4;
    localparam int NIB     = 4;
    localparam int NPIN    = G0_W + G1_W + G2_W + G3_W;
    localparam int NIB_PINS = G0_W + G1_W;
    localparam int NHZ_NIB = NIB_PINS / NIB;
    localparam int NHZ     = NHZ_NIB + G2_W + G3_W;
    localparam int REG_W   = 8;
    localparam int ADDR_W  = 3;
    localparam int BUS_AW  = 20;
    localparam int NCE     = 3;

    localparam int OFS_D0  = 0;
    localparam int OFS_D1  = 1;
    localparam int OFS_D2  = 2;
    localparam int OFS_D3  = 3;
    localparam int OFS_HZN = 4;
    localparam int OFS_HZ2 = 5;
    localparam int OFS_HZ3 = 6;

    // Index of the tristate control bit that governs a given pin.
    function automatic int hz_sel(input int pin);
        if (pin < NIB_PINS) return pin / NIB;
        return NHZ_NIB + pin - NIB_PINS;
    endfunction
endpackage

// File: rtl/outport_regfile.sv
// Register file of the output port bank.
// Holds the per-group data registers and the tristate controls, with a
// combinational read mux. Assumes a single-cycle write strobe, sampled at
// the clock edge. Unused bits are not stored and read as 0.
module outport_regfile
    import outport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic [NPIN-1:0]   data_flat,
    output logic [NHZ-1:0]    hz_flat
);
    logic [G0_W-1:0]    g0_q;
    logic [G1_W-1:0]    g1_q;
    logic [G2_W-1:0]    g2_q;
    logic [G3_W-1:0]    g3_q;
    logic [NHZ_NIB-1:0] hzn_q;
    logic [G2_W-1:0]    hz2_q;
    logic [G3_W-1:0]    hz3_q;
    logic               past_ok;

    // Store a write into the register selected by addr.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g0_q  <= '0;
            g1_q  <= '0;
            g2_q  <= '0;
            g3_q  <= '0;
            hzn_q <= '0;
            hz2_q <= '0;
            hz3_q <= '0;
        end else if (wr_en) begin
            case (addr)
                ADDR_W'(OFS_D0):  g0_q  <= wdata[G0_W-1:0];
                ADDR_W'(OFS_D1):  g1_q  <= wdata[G1_W-1:0];
                ADDR_W'(OFS_D2):  g2_q  <= wdata[G2_W-1:0];
                ADDR_W'(OFS_D3):  g3_q  <= wdata[G3_W-1:0];
                ADDR_W'(OFS_HZN): hzn_q <= wdata[NHZ_NIB-1:0];
                ADDR_W'(OFS_HZ2): hz2_q <= wdata[G2_W-1:0];
                ADDR_W'(OFS_HZ3): hz3_q <= wdata[G3_W-1:0];
                default: ;
            endcase
        end
    end

    // Return the addressed register, zero-extended.
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(OFS_D0):  rdata[G0_W-1:0]    = g0_q;
            ADDR_W'(OFS_D1):  rdata[G1_W-1:0]    = g1_q;
            ADDR_W'(OFS_D2):  rdata[G2_W-1:0]    = g2_q;
            ADDR_W'(OFS_D3):  rdata[G3_W-1:0]    = g3_q;
            ADDR_W'(OFS_HZN): rdata[NHZ_NIB-1:0] = hzn_q;
            ADDR_W'(OFS_HZ2): rdata[G2_W-1:0]    = hz2_q;
            ADDR_W'(OFS_HZ3): rdata[G3_W-1:0]    = hz3_q;
            default: ;
        endcase
    end

    assign data_flat = {g3_q, g2_q, g1_q, g0_q};
    assign hz_flat   = {hz3_q, hz2_q, hzn_q};

    // Marks cycles whose previous edge was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R2: a write to group 2 data keeps exactly its six stored bits
    p_wr_g2_r2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(wr_en) && ($past(addr) == ADDR_W'(OFS_D2))
        |-> g2_q == $past(wdata[G2_W-1:0]));

    // R6: without a write strobe no register changes
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(wr_en) |-> $stable(data_flat) && $stable(hz_flat));
endmodule

// File: rtl/outport_hz_expand.sv
// Expands the 14 tristate control bits to one tristate flag per pin.
// Groups 0 and 1 share one control per nibble; groups 2 and 3 map one to one.
// Purely combinational.
module outport_hz_expand
    import outport_pkg::*;
(
    input  logic [NHZ-1:0]  hz_flat,
    output logic [NPIN-1:0] hz_pin
);
    // One wire per pin, selected from its control bit.
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        assign hz_pin[i] = hz_flat[hz_sel(i)];
    end
endmodule

// File: rtl/outport_pin_mux.sv
// Output register stage of the port bank.
// Selects register-driven or bus-driven pins by mode and registers both the
// values and the enables. Assumes mode_exp is held stable by the system.
module outport_pin_mux
    import outport_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_exp,
    input  logic [NPIN-1:0] data_flat,
    input  logic [NPIN-1:0] hz_pin,
    input  logic [NPIN-1:0] bus_vec,
    output logic [NPIN-1:0] pin_out,
    output logic [NPIN-1:0] pin_oe
);
    logic past_ok;

    // Register the pin values and enables for the selected mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_out <= '0;
            pin_oe  <= '1;
        end else if (mode_exp) begin
            pin_out <= bus_vec;
            pin_oe  <= '1;
        end else begin
            pin_out <= data_flat & ~hz_pin;
            pin_oe  <= ~hz_pin;
        end
    end

    // Marks cycles whose previous edge was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R7: expansion mode enables every pin
    p_bus_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(mode_exp) |-> &pin_oe);

    // R7: expansion mode passes the bus through unchanged
    p_bus_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(mode_exp) |-> pin_out == $past(bus_vec));

    // R3: a floating pin never shows a 1
    p_hiz_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0);
endmodule

// File: rtl/outport_bank.sv
// Top of the output port bank.
// Ties the register file, the tristate expansion and the pin output stage
// together, and packs the external bus signals into pin order.
// Assumes a synchronous active-low reset held for at least one clock edge.
module outport_bank
    import outport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_exp,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [NCE-1:0]    bus_ce,
    input  logic              bus_ack,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe
);
    logic [NPIN-1:0] data_flat;
    logic [NHZ-1:0]  hz_flat;
    logic [NPIN-1:0] hz_pin;
    logic [NPIN-1:0] bus_vec;
    logic            past_ok;

    assign bus_vec = {bus_ack, bus_ce, bus_wr, bus_rd, bus_addr};

    outport_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .data_flat (data_flat),
        .hz_flat   (hz_flat)
    );

    outport_hz_expand u_hz (
        .hz_flat (hz_flat),
        .hz_pin  (hz_pin)
    );

    outport_pin_mux u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_exp  (mode_exp),
        .data_flat (data_flat),
        .hz_pin    (hz_pin),
        .bus_vec   (bus_vec),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    // Marks cycles whose previous edge was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R3: the group 0 low-nibble control floats pins 0 to 3
    p_nib_hz_r3: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(mode_exp) && $past(hz_flat[0])
        |-> pin_oe[NIB-1:0] == '0);

    // R4: the last pin follows its data bit when its control is clear
    p_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(mode_exp) && !$past(hz_flat[NHZ-1])
        |-> pin_oe[NPIN-1] && (pin_out[NPIN-1] == $past(data_flat[NPIN-1])));
endmodule

// File: tb/outport_bank_test.sv
module outport_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_exp = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [19:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_ce = '0;
    logic        bus_ack = 1'b0;
    logic [25:0] pin_out;
    logic [25:0] pin_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [25:0] m_data = '0;
    logic [13:0] m_hz = '0;

    always #4 clk = ~clk;

    outport_bank uut (
        .clk(clk), .rst_n(rst_n), .mode_exp(mode_exp),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_ce(bus_ce), .bus_ack(bus_ack),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input bit ok, input string tag, input logic [25:0] act, input logic [25:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [25:0] exp_hzp();
        logic [25:0] v;
        for (int i = 0; i < 26; i++) v[i] = (i < 16) ? m_hz[i / 4] : m_hz[i - 12];
        return v;
    endfunction

    task automatic chk_pins(input string tag);
        logic [25:0] h;
        h = exp_hzp();
        chk(pin_oe == ~h, {tag, " oe"}, pin_oe, ~h);
        chk(pin_out == (m_data & ~h), {tag, " out"}, pin_out, m_data & ~h);
    endtask

    // Write one register at the next edge and track it in the model.
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        case (a)
            3'd0: m_data[7:0]   = d;
            3'd1: m_data[15:8]  = d;
            3'd2: m_data[21:16] = d[5:0];
            3'd3: m_data[25:22] = d[3:0];
            3'd4: m_hz[3:0]     = d[3:0];
            3'd5: m_hz[9:4]     = d[5:0];
            3'd6: m_hz[13:10]   = d[3:0];
            default: ;
        endcase
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] e, input string tag);
        reg_addr = a;
        #1;
        chk(reg_rdata == e, tag, 26'(reg_rdata), 26'(e));
    endtask

    task automatic t_reset;
        chk(pin_oe == '1, "R1 reset oe", pin_oe, '1);
        chk(pin_out == '0, "R1 reset out", pin_out, '0);
        for (int a = 0; a < 7; a++) rd_chk(3'(a), 8'h00, "R1 reset read");
    endtask

    task automatic t_map;
        logic [7:0] e [8] = '{8'hFF, 8'hFF, 8'h3F, 8'h0F, 8'h0F, 8'h3F, 8'h0F, 8'h00};
        for (int a = 0; a < 8; a++) wr(3'(a), 8'hFF);
        for (int a = 0; a < 8; a++) rd_chk(3'(a), e[a], "R2 map readback");
        for (int a = 0; a < 8; a++) wr(3'(a), 8'h00);
        @(negedge clk);
        chk_pins("R2 cleared");
    endtask

    task automatic t_drive;
        wr(3'd0, 8'hA5);
        chk(pin_out == '0, "R6 pin not yet updated", pin_out, '0);
        @(negedge clk);
        chk_pins("R6 R4 group0 after one edge");
        wr(3'd1, 8'h3C);
        wr(3'd2, 8'h2A);
        wr(3'd3, 8'h09);
        @(negedge clk);
        chk_pins("R4 all groups");
        wr(3'd3, 8'h06);
        @(negedge clk);
        chk_pins("R4 group3 pattern");
    endtask

    task automatic t_hz;
        wr(3'd0, 8'hFF); wr(3'd1, 8'hFF); wr(3'd2, 8'h3F); wr(3'd3, 8'h0F);
        wr(3'd4, 8'h05);
        @(negedge clk);
        chk_pins("R3 low nibbles floated");
        chk(pin_oe[15:0] == 16'hF0F0, "R3 nibble oe", 26'(pin_oe[15:0]), 26'hF0F0);
        wr(3'd4, 8'h0A);
        wr(3'd5, 8'h21);
        wr(3'd6, 8'h04);
        @(negedge clk);
        chk_pins("R3 high nibbles and single bits");
        chk(pin_oe[25:16] == 10'b1011_011110, "R3 per-pin oe", 26'(pin_oe[25:16]), 26'(10'b1011_011110));
        wr(3'd4, 8'h00); wr(3'd5, 8'h00); wr(3'd6, 8'h00);
        @(negedge clk);
        chk_pins("R3 all driven again");
    endtask

    task automatic t_hold;
        wr(3'd2, 8'h00);
        wr(3'd5, 8'h08);
        wr(3'd2, 8'h08);
        @(negedge clk);
        chk(pin_out[19] == 1'b0 && pin_oe[19] == 1'b0, "R5 held while floating", 26'({pin_oe[19], pin_out[19]}), 26'b00);
        wr(3'd5, 8'h00);
        @(negedge clk);
        chk(pin_out[19] == 1'b1 && pin_oe[19] == 1'b1, "R5 held value revealed", 26'({pin_oe[19], pin_out[19]}), 26'b11);
        chk_pins("R5 full vector");
    endtask

    task automatic t_exp;
        logic [25:0] e;
        wr(3'd4, 8'h0F);
        @(negedge clk);
        mode_exp = 1'b1;
        bus_addr = 20'hABCDE; bus_rd = 1'b1; bus_wr = 1'b0; bus_ce = 3'b101; bus_ack = 1'b1;
        @(negedge clk);
        e = {1'b1, 3'b101, 1'b0, 1'b1, 20'hABCDE};
        chk(pin_out == e, "R7 bus pattern 1", pin_out, e);
        chk(pin_oe == '1, "R7 all enabled", pin_oe, '1);
        bus_addr = 20'h12345; bus_rd = 1'b0; bus_wr = 1'b1; bus_ce = 3'b010; bus_ack = 1'b0;
        @(negedge clk);
        e = {1'b0, 3'b010, 1'b1, 1'b0, 20'h12345};
        chk(pin_out == e, "R7 bus pattern 2", pin_out, e);
    endtask

    task automatic t_exp_regs;
        logic [25:0] e;
        e = {1'b0, 3'b010, 1'b1, 1'b0, 20'h12345};
        wr(3'd0, 8'h5A);
        wr(3'd4, 8'h02);
        wr(3'd6, 8'h09);
        @(negedge clk);
        chk(pin_out == e && pin_oe == '1, "R8 pins untouched in expansion", pin_out, e);
        rd_chk(3'd0, 8'h5A, "R8 data readback in expansion");
        rd_chk(3'd4, 8'h02, "R8 control readback in expansion");
        rd_chk(3'd6, 8'h09, "R8 group3 control readback");
        mode_exp = 1'b0;
        @(negedge clk);
        chk_pins("R8 registers restored on return");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_drive();
        t_hz();
        t_hold();
        t_exp();
        t_exp_regs();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule